// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a memory-mapped countdown timer for a processor's local interrupt controller. A register bus with one-cycle reads and writes gives access to four registers. The first is a control word that picks one-shot or repeating operation and holds an interrupt mask bit and an 8-bit vector. The others are a start-count register that can be read and written, a live-count register that can only be read, and a prescale register. The prescaler divides the bus clock and so sets the rate at which the live count steps down.

Software writes the start count to launch a countdown. When the count reaches zero, the block raises a one-cycle interrupt request together with the vector. In one-shot operation the count then stays at zero. In repeating operation it reloads from the start count and runs again. Writing zero stops the timer. Writing a new nonzero start count in the middle of a run restarts the run from that value.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset, a read of the control word (offset 0x320) returns 0x0001_0000, with the mask set. Reads of the start count (0x380), the live count (0x390) and the prescale register (0x3E0) return 0. A read of any other offset returns 0. Read data and `bus_rvalid` appear in the cycle after `bus_rd` is sampled.
- R2: The prescale code sits in bits [2:0] of offset 0x3E0. Codes 0 to 6 divide the clock by 2, 4, 8, 16, 32, 64 and 128. Code 7 divides by 1. A write to this register restarts the prescaler.
- R3: A write of a nonzero N to the start count loads N into the live count and restarts the prescaler. Each later tick lowers the live count by one. With divider D, the interrupt pulse is high in the cycle that begins N·D clock edges after the edge that sampled the write.
- R4: In one-shot operation (control bit 17 = 0), the live count holds at 0 after the interrupt until the start count is written again.
- R5: In repeating operation (control bit 17 = 1), the live count reloads from the start count when it reaches zero, so interrupts repeat every N·D cycles.
- R6: Writing 0 to the start count sets the live count to 0 and stops the timer in either mode. No interrupt follows.
- R7: A write to the start count during a countdown discards the old run. The only interrupt comes N·D cycles after the new write.
- R8: Bus writes to the live count (0x390) are ignored.
- R9: While the mask (control bit 16) is 1, `irq_pulse` stays low but counting goes on. While `irq_pulse` is high, `irq_vector` carries control bits [7:0]. At all other times `irq_vector` is 0.
- R10: Each time the count reaches zero, `irq_pulse` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector for the interrupt request |

## Verification
The hardest case to reach from the ports is a countdown that stays in an exact relation to the bus clock. Several examples are a read of the live count partway through a divide-by-2 run, the interrupt 256 cycles after a write under divide-by-128, and a stop or restart written a few cycles before a pending zero. The driver records the exact clock edge on which each write is sampled. From that edge it computes the expected interrupt cycles and the expected live-count values. It places the stop and restart writes at chosen offsets from those edges, so each one lands before an interrupt that would otherwise have occurred.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int VEC_W = 8;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } ctrl_word_t;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter int          CODE_W  = 3,
  parameter int          PER_BIT = 17,
  parameter int          MSK_BIT = 16,
  parameter logic [11:0] OFF_CTL = 12'h320,
  parameter logic [11:0] OFF_INI = 12'h380,
  parameter logic [11:0] OFF_CUR = 12'h390,
  parameter logic [11:0] OFF_DIV = 12'h3E0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [DATA_W-1:0]      live_cnt,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rvalid,
  output cdt_pkg::ctrl_word_t    ctrl,
  output logic [DATA_W-1:0]      start_cnt,
  output logic [CODE_W-1:0]      div_code,
  output logic                   load,
  output logic [DATA_W-1:0]      load_val,
  output logic                   pre_restart
);
  localparam int VW = cdt_pkg::VEC_W;

  logic hit_ctl, hit_ini, hit_cur, hit_div;
  assign hit_ctl = (addr == ADDR_W'(OFF_CTL));
  assign hit_ini = (addr == ADDR_W'(OFF_INI));
  assign hit_cur = (addr == ADDR_W'(OFF_CUR));
  assign hit_div = (addr == ADDR_W'(OFF_DIV));

  assign load        = wr && hit_ini;
  assign load_val    = wdata;
  assign pre_restart = wr && (hit_ini || hit_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.periodic <= 1'b0;
      ctrl.mask     <= 1'b1;
      ctrl.vector   <= '0;
      start_cnt     <= '0;
      div_code      <= '0;
    end else if (wr) begin
      if (hit_ctl) begin
        ctrl.periodic <= wdata[PER_BIT];
        ctrl.mask     <= wdata[MSK_BIT];
        ctrl.vector   <= wdata[VW-1:0];
      end
      if (hit_ini) start_cnt <= wdata;
      if (hit_div) div_code  <= wdata[CODE_W-1:0];
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctl) begin
      rd_mux[PER_BIT]  = ctrl.periodic;
      rd_mux[MSK_BIT]  = ctrl.mask;
      rd_mux[VW-1:0]   = ctrl.vector;
    end else if (hit_ini) begin
      rd_mux = start_cnt;
    end else if (hit_cur) begin
      rd_mux = live_cnt;
    end else if (hit_div) begin
      rd_mux[CODE_W-1:0] = div_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PRE_W = (1 << CODE_W) - 1;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] limit;

  always_comb begin
    if (code == {CODE_W{1'b1}}) begin
      span = '0;
      limit = '0;
    end else begin
      span  = (PRE_W+1)'(1) << (code + 1'b1);
      limit = PRE_W'(span - 1'b1);
    end
  end

  assign tick = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  input  logic              periodic,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] cnt,
  output logic              fire
);
  logic at_one;
  assign at_one = (cnt == DATA_W'(1));
  assign fire   = !load && tick && at_one;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (tick && cnt != '0) begin
      if (at_one) cnt <= periodic ? reload_val : '0;
      else        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CODE_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_rvalid,
  output logic                       irq_pulse,
  output logic [cdt_pkg::VEC_W-1:0]  irq_vector
);
  cdt_pkg::ctrl_word_t ctrl;
  logic [DATA_W-1:0]   start_cnt, live_cnt, load_val;
  logic [CODE_W-1:0]   div_code;
  logic                load, pre_restart, tick, fire;

  cdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .live_cnt(live_cnt), .rdata(bus_rdata),
    .rvalid(bus_rvalid), .ctrl(ctrl), .start_cnt(start_cnt),
    .div_code(div_code), .load(load), .load_val(load_val),
    .pre_restart(pre_restart)
  );

  cdt_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(pre_restart), .code(div_code), .tick(tick)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .tick(tick),
    .periodic(ctrl.periodic), .reload_val(start_cnt), .cnt(live_cnt),
    .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse  <= fire && !ctrl.mask;
      irq_vector <= (fire && !ctrl.mask) ? ctrl.vector : '0;
    end
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [DATA_W-1:0] load_val,
  input logic              tick,
  input logic              periodic,
  input logic              mask,
  input logic [DATA_W-1:0] start_cnt,
  input logic [DATA_W-1:0] live_cnt,
  input logic              irq_pulse
);
  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && live_cnt > DATA_W'(1)) |=> live_cnt == $past(live_cnt) - 1'b1);

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && live_cnt == '0) |=> live_cnt == '0);

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && periodic && live_cnt == DATA_W'(1)) |=> live_cnt == $past(start_cnt));

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> live_cnt == $past(load_val));

  assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> !$past(mask));

  assert_pulse_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> ($past(live_cnt) == DATA_W'(1) && $past(tick) && !$past(load)));
endmodule

bind countdown_irq_timer cdt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .load_val(load_val), .tick(tick),
  .periodic(ctrl.periodic), .mask(ctrl.mask), .start_cnt(start_cnt),
  .live_cnt(live_cnt), .irq_pulse(irq_pulse)
);

// File: tb/countdown_irq_timer_tb.sv
module countdown_irq_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTL = 12'h320, A_INI = 12'h380,
                          A_CUR = 12'h390, A_DIV = 12'h3E0;

  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_rvalid, irq_pulse;
  logic [7:0]  irq_vector;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  int          irq_cyc_q[$];
  logic [7:0]  irq_vec_q[$];
  string       irq_tag_q[$];

  countdown_irq_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output int at);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; at = cyc + 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic read_mid(input int start, input int n, input int d, input string tag);
    int at;
    @(negedge clk);
    at = cyc + 1;
    rd_exp_q.push_back(32'(n - (at - 1 - start) / d)); rd_tag_q.push_back(tag);
    bus_rd = 1; bus_addr = A_CUR;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic expect_irq(input int c, input logic [7:0] v, input string tag);
    irq_cyc_q.push_back(c); irq_vec_q.push_back(v); irq_tag_q.push_back(tag);
  endtask

  always @(negedge clk) if (!rst) begin
    if (bus_rvalid) begin
      checks++;
      if (rd_exp_q.size() == 0) begin
        errors++; $display("FAIL R1 unexpected read data %h expected none", bus_rdata);
      end else begin
        logic [31:0] e; string t;
        e = rd_exp_q.pop_front(); t = rd_tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++; $display("FAIL %s read got %h expected %h", t, bus_rdata, e);
        end
      end
    end
    if (irq_pulse) begin
      checks++;
      if (irq_cyc_q.size() == 0) begin
        errors++; $display("FAIL R6/R9/R10 unexpected irq at %0d expected none", cyc);
      end else begin
        int c; logic [7:0] v; string t;
        c = irq_cyc_q.pop_front(); v = irq_vec_q.pop_front(); t = irq_tag_q.pop_front();
        if (c != cyc || irq_vector !== v) begin
          errors++;
          $display("FAIL %s irq at %0d vec %h expected %0d vec %h", t, cyc, irq_vector, c, v);
        end
      end
    end else if (irq_vector !== 8'h00) begin
      checks++; errors++;
      $display("FAIL R9 idle vector %h expected 00", irq_vector);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w, w2;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state and unmapped offsets
    bus_read(A_CTL, 32'h0001_0000, "R1 ctl");
    bus_read(A_INI, 32'h0, "R1 ini");
    bus_read(A_CUR, 32'h0, "R1 cur");
    bus_read(A_DIV, 32'h0, "R1 div");
    bus_read(12'h3A0, 32'h0, "R1 unmapped");

    // R3/R4 one-shot, divide by 1 (code 7)
    bus_write(A_CTL, 32'h0000_0041, w);
    bus_write(A_DIV, 32'h7, w);
    bus_read(A_DIV, 32'h7, "R2 div readback");
    bus_write(A_INI, 32'd5, w);
    expect_irq(w + 5, 8'h41, "R3 oneshot div1");
    repeat (12) @(negedge clk);
    bus_read(A_CUR, 32'h0, "R4 hold zero");

    // R2 divide by 8 (code 2) and by 128 (code 6)
    bus_write(A_DIV, 32'h2, w);
    bus_write(A_INI, 32'd3, w);
    expect_irq(w + 24, 8'h41, "R2 div8");
    repeat (30) @(negedge clk);
    bus_write(A_DIV, 32'h6, w);
    bus_write(A_INI, 32'd2, w);
    expect_irq(w + 256, 8'h41, "R2 div128");
    repeat (265) @(negedge clk);

    // R3 mid-count reads under divide by 2
    bus_write(A_DIV, 32'h0, w);
    bus_write(A_INI, 32'd20, w);
    expect_irq(w + 40, 8'h41, "R2 div2");
    repeat (4) @(negedge clk);
    read_mid(w, 20, 2, "R3 mid count a");
    repeat (5) @(negedge clk);
    read_mid(w, 20, 2, "R3 mid count b");
    repeat (40) @(negedge clk);

    // R5 periodic then R6 stop by zero write
    bus_write(A_CTL, 32'h0002_0055, w);
    bus_write(A_DIV, 32'h7, w);
    bus_write(A_INI, 32'd4, w);
    expect_irq(w + 4, 8'h55, "R5 period 1");
    expect_irq(w + 8, 8'h55, "R5 period 2");
    expect_irq(w + 12, 8'h55, "R5 period 3");
    while (cyc < w + 13) @(negedge clk);
    bus_write(A_INI, 32'd0, w2);
    repeat (12) @(negedge clk);
    bus_read(A_CUR, 32'h0, "R6 stopped");

    // R7 restart during countdown (one-shot)
    bus_write(A_CTL, 32'h0000_0066, w);
    bus_write(A_INI, 32'd10, w);
    repeat (3) @(negedge clk);
    bus_write(A_INI, 32'd6, w2);
    expect_irq(w2 + 6, 8'h66, "R7 restart");
    repeat (15) @(negedge clk);

    // R9 masked: no irq, count still reaches zero
    bus_write(A_CTL, 32'h0001_0033, w);
    bus_write(A_INI, 32'd3, w);
    repeat (10) @(negedge clk);
    bus_read(A_CUR, 32'h0, "R9 masked count ran");

    // R8 live-count write ignored
    bus_write(A_DIV, 32'h6, w);
    bus_write(A_INI, 32'd1000, w);
    bus_write(A_CUR, 32'h99, w2);
    bus_read(A_CUR, 32'd1000, "R8 write ignored");
    bus_write(A_INI, 32'd0, w);
    repeat (10) @(negedge clk);

    checks++;
    if (irq_cyc_q.size() != 0 || rd_exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending items got %0d irq %0d rd expected 0", irq_cyc_q.size(), rd_exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule